// File: doc/BRIEF.md
# Key-Guarded Mode Configuration Write Gate

This block holds a single lock bit that decides whether the direction and mode configuration registers of one or more GPIO banks may be written. Software opens the gate by writing a fixed 16-bit key into the low half of the lock word. It closes the gate again by writing zero into that half. Every other value leaves the gate as it is, so a stray or corrupted store cannot open it.

The lock word sits in an 8-byte window on a plain 32-bit register bus. The bus carries a byte address, a write strobe, write data and read data. The top bit of the lock word reads back the gate state. The second word of the window reads as zero and ignores writes. The registered gate state is sent to every bank as a per-bank mode write enable. That enable comes straight from a flop, so no combinational path runs from the bus write data to the banks.

Top module: `keylock_gate`

## Requirements
- R1: After reset the gate is closed: every `mode_we` bit is 0 and a read of the lock word returns 0.
- R2: A write to the lock word (byte address BASE, or BASE+1..BASE+3, since address bits [1:0] are ignored) whose bits [15:0] equal the key 0xd42f opens the gate. Bits [31:16] of that write are ignored.
- R3: A write to the lock word whose bits [15:0] are 0x0000 closes the gate.
- R4: A write to the lock word whose bits [15:0] are neither the key nor zero leaves the gate state unchanged.
- R5: A read of the lock word returns the gate state in bit 31, and bits [30:0] read as 0.
- R6: The second word of the window (byte address BASE+4) reads as 0, and writes to it have no effect on the gate.
- R7: Addresses outside the 8-byte window read as 0, and writes to them have no effect on the gate.
- R8: Every bit of `mode_we` equals the registered gate state. It changes on the clock edge that takes the write, not in the cycle the write is presented.
- R9: Read data in the cycle of a write shows the gate state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| mode_we | output | NUM_BANKS (3) | Mode register write enable, one bit per bank |

## Verification
A read of the lock word and a write to it can fall in the same cycle. Read data is combinational from the state register, so it must show the state from before the write, while `mode_we` must change only after the edge. The bench drives a write at every key-field value, 65536 in all, on consecutive cycles. In each cycle it samples the read data before the edge and compares it with the model's old state. After the edge it compares `mode_we` with the model's new state.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int unsigned KEY_W      = 16;
  localparam logic [15:0] OPEN_KEY   = 16'hd42f;
  localparam logic [15:0] CLOSE_CODE = 16'h0000;
  localparam int unsigned WIN_BITS   = 3;  // 8-byte window
endpackage

// File: rtl/keylock_rst_sync.sv
module keylock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/keylock_decode.sv
module keylock_decode
  import keylock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h088
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_lock,
  output logic              hit_spare
);
  logic in_win;

  always_comb begin
    in_win    = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
    hit_lock  = in_win && !addr[2];
    hit_spare = in_win &&  addr[2];
  end
endmodule

// File: rtl/keylock_next.sv
module keylock_next
  import keylock_pkg::*;
(
  input  logic             wr_lock,
  input  logic [KEY_W-1:0] key_field,
  output logic             upd_en,
  output logic             upd_val
);
  logic is_key;
  logic is_close;

  always_comb begin
    is_key   = (key_field == OPEN_KEY);
    is_close = (key_field == CLOSE_CODE);
    upd_en   = wr_lock && (is_key || is_close);
    upd_val  = is_key;
  end
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
  import keylock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h088,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_BANKS-1:0] mode_we
);
  localparam int unsigned STAT_BIT = DATA_W - 1;

  logic rst_int_n;
  logic hit_lock, hit_spare;
  logic upd_en, upd_val;
  logic open_q, open_d;

  keylock_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  keylock_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .hit_lock(hit_lock), .hit_spare(hit_spare)
  );

  keylock_next u_nxt (
    .wr_lock(bus_wr && hit_lock),
    .key_field(bus_wdata[KEY_W-1:0]),
    .upd_en(upd_en),
    .upd_val(upd_val)
  );

  always_comb open_d = upd_en ? upd_val : open_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) open_q <= 1'b0;
    else if (upd_en) open_q <= open_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_lock) bus_rdata[STAT_BIT] = open_q;
    else if (hit_spare) bus_rdata = '0;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mode_we[b] = open_q;
  end
endmodule

// File: rtl/keylock_checker.sv
module keylock_checker #(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h088,
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned DATA_W    = 32
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_BANKS-1:0] mode_we
);
  logic lock_sel;
  logic wr_key, wr_zero, wr_other;
  assign lock_sel = (bus_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && !bus_addr[2];
  assign wr_key   = bus_wr && lock_sel && (bus_wdata[15:0] == 16'hd42f);
  assign wr_zero  = bus_wr && lock_sel && (bus_wdata[15:0] == 16'h0000);
  assign wr_other = bus_wr && lock_sel && !wr_key && !wr_zero;

  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_key |=> mode_we[0]);
  p_zero_closes_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_zero |=> !mode_we[0]);
  p_other_holds_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_other |=> $stable(mode_we));
  p_status_bit_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_sel |-> (bus_rdata[DATA_W-1] == mode_we[0] && bus_rdata[DATA_W-2:0] == '0));
  p_miss_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lock_sel |-> bus_rdata == '0);
  p_miss_holds_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_wr && lock_sel) |=> $stable(mode_we));
  p_banks_agree_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_we == {NUM_BANKS{mode_we[0]}});
endmodule

bind keylock_gate keylock_checker #(
  .ADDR_W(ADDR_W), .BASE(BASE), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_we(mode_we)
);

// File: tb/sim_keylock_gate.sv
module sim_keylock_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LOCK_A  = 12'h088;
  localparam logic [11:0] SPARE_A = 12'h08C;
  localparam logic [11:0] OUT_A   = 12'h090;
  localparam logic [15:0] KEY     = 16'hd42f;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] mode_we;

  int checks = 0;
  int errors = 0;
  logic model = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylock_gate u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_we(mode_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; old-state read check before edge, new-state check after
  task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic [31:0] rd_exp, input logic nxt, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    #1 chk({tag, " R9 rdata"}, bus_rdata, rd_exp);
    @(posedge clk);
    #1 chk({tag, " R8 mode_we"}, {29'b0, mode_we}, {29'b0, {3{nxt}}});
    model = nxt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R1 actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_addr = LOCK_A;
    #1 chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 mode_we", {29'b0, mode_we}, 32'h0);

    // R2/R3/R4 sweep of every key field value
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] lo;
      logic nxt;
      lo = i[15:0];
      nxt = (lo == KEY) ? 1'b1 : (lo == 16'h0) ? 1'b0 : model;
      cyc(LOCK_A + 12'(i % 4), 1'b1, {16'(i * 40503), lo}, {model, 31'b0}, nxt, "R2R3R4 sweep");
    end
    chk("R4 end open", {31'b0, model}, 32'h1);

    // R5 read of open gate
    cyc(LOCK_A, 1'b0, 32'hffff_ffff, 32'h8000_0000, 1'b1, "R5 read");
    // R6 spare word: reads zero, writes ignored
    cyc(SPARE_A, 1'b1, 32'h0, 32'h0, 1'b1, "R6 spare zero");
    cyc(SPARE_A, 1'b1, 32'h1234_0000, 32'h0, 1'b1, "R6 spare write");
    // R7 outside window
    cyc(OUT_A, 1'b1, 32'h0, 32'h0, 1'b1, "R7 outside");
    cyc(12'h080, 1'b1, 32'h0, 32'h0, 1'b1, "R7 below");
    // R3 close, then R6/R7 key writes elsewhere do not open
    cyc(LOCK_A, 1'b1, 32'hffff_0000, 32'h8000_0000, 1'b0, "R3 close");
    cyc(SPARE_A, 1'b1, {16'h0, KEY}, 32'h0, 1'b0, "R6 key to spare");
    cyc(OUT_A, 1'b1, {16'h0, KEY}, 32'h0, 1'b0, "R7 key outside");
    cyc(LOCK_A, 1'b1, {16'h0, KEY ^ 16'h0001}, 32'h0, 1'b0, "R4 near key");
    cyc(LOCK_A, 1'b1, {16'hdead, KEY}, 32'h0, 1'b1, "R2 key upper bits");

    // R1 reset mid-operation closes the gate
    @(negedge clk);
    bus_wr = 1'b0;
    rst_n = 1'b0;
    #1 chk("R1 async reset", {29'b0, mode_we}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_addr = LOCK_A;
    #1 chk("R1 after reset rdata", bus_rdata, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule